// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block picks, every clock, the address of the next microinstruction that a microprogrammed control unit reads from its 128-word control store. It holds a 7-bit control address register and a one-deep link register for subroutines. The sequencing fields of the current microinstruction arrive as inputs: a condition selector, a branch kind and a 7-bit target. The machine opcode bits and three status flags also arrive as inputs. The block's only output is the registered control address, which drives the control store's read port directly.

The branch kind selects one of four moves. A jump goes to the target when the selected condition holds and steps forward otherwise. A call does the same and also stores the return point. A return reloads the stored return point. A map turns the opcode into the entry address of that opcode's routine. The lower 64 addresses hold the per-opcode routines, which are four words apart. The upper 64 addresses hold the fetch routine and shared subroutines. Reset starts execution in the fetch routine at address 64.

Top module: `useq_sequencer`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets `car` to 64 and clears the link register to 0. A return issued just after reset therefore yields address 0.
- R2: `cond_sel` chooses the branch condition: 00 is always true, 01 is `ind_bit`, 10 is `sign_bit` and 11 is `zero_flag`.
- R3: When `br_kind` is 00 (jump), the next `car` is `target` if the condition is true and `car`+1 otherwise.
- R4: When `br_kind` is 01 (call) and the condition is true, the next `car` is `target` and the link register takes `car`+1. When the condition is false, the next `car` is `car`+1 and the link register is left unchanged.
- R5: When `br_kind` is 10 (return), the next `car` is the link register value, whatever the condition.
- R6: When `br_kind` is 11 (map), the next `car` is {0, `op_bits`[3:0], 00}, so routines begin at 0, 4, ... 60. The condition and `target` are ignored.
- R7: The step `car`+1 wraps modulo 128, so address 127 is followed by 0. This also applies to the link value stored by a call.
- R8: The link register holds one level only. A second call overwrites it, and every later return goes to the second call's return point.
- R9: The link register changes only on a taken call. Jumps, maps, returns and untaken calls leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cond_sel | input | 2 | Condition selector field of the current microinstruction |
| br_kind | input | 2 | Branch kind field: 00 jump, 01 call, 10 return, 11 map |
| target | input | 7 | Address field of the current microinstruction |
| op_bits | input | 4 | Machine opcode bits used by the map |
| ind_bit | input | 1 | Indirect-address status bit |
| sign_bit | input | 1 | Accumulator sign status bit |
| zero_flag | input | 1 | Accumulator-is-zero status bit |
| car | output | 7 | Control address register, read address of the control store |

## Verification
Each condition selector is run with its own flag set and then cleared while the other flags are held at the opposite value. This shows that the right source is chosen and that a taken branch differs from a fall-through. Call/return sequences tell a stored link apart from a stale one: they include untaken calls, nested calls and jumps or maps inside a subroutine. All sixteen opcodes are mapped with a false condition and an unrelated target, which shows that the map uses only the opcode. Running past address 127 separates modulo wrap from overflow, both in the step and in the stored link.

// File: rtl/useq_pkg.sv
package useq_pkg;
  typedef enum logic [1:0] {
    BR_JUMP = 2'b00,
    BR_CALL = 2'b01,
    BR_RET  = 2'b10,
    BR_MAP  = 2'b11
  } br_kind_t;

  typedef enum logic [1:0] {
    CS_ALWAYS = 2'b00,
    CS_IND    = 2'b01,
    CS_SIGN   = 2'b10,
    CS_ZERO   = 2'b11
  } cond_sel_t;
endpackage

// File: rtl/useq_cond_mux.sv
module useq_cond_mux #(
  parameter int N_SRC = 4,
  localparam int SEL_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] src,
  input  logic [SEL_W-1:0] sel,
  output logic             hit
);
  always_comb hit = src[sel];
endmodule

// File: rtl/useq_map.sv
module useq_map #(
  parameter int ADDR_W  = 7,
  parameter int OP_W    = 4,
  parameter int MAP_LSB = 2
) (
  input  logic [OP_W-1:0]   op,
  output logic [ADDR_W-1:0] entry
);
  for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
    if (b >= MAP_LSB && b < MAP_LSB + OP_W) begin : g_op
      assign entry[b] = op[b-MAP_LSB];
    end else begin : g_zero
      assign entry[b] = 1'b0;
    end
  end
endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr
  import useq_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic [ADDR_W-1:0] car,
  input  logic [ADDR_W-1:0] link,
  input  logic [ADDR_W-1:0] target,
  input  logic [ADDR_W-1:0] map_entry,
  input  br_kind_t          kind,
  input  logic              taken,
  output logic [ADDR_W-1:0] nxt,
  output logic              link_we,
  output logic [ADDR_W-1:0] link_val
);
  localparam logic [ADDR_W-1:0] STEP = 1;
  logic [ADDR_W-1:0] seq;

  always_comb begin
    seq      = car + STEP;
    link_we  = 1'b0;
    link_val = seq;
    unique case (kind)
      BR_JUMP: nxt = taken ? target : seq;
      BR_CALL: begin
        nxt     = taken ? target : seq;
        link_we = taken;
      end
      BR_RET:  nxt = link;
      BR_MAP:  nxt = map_entry;
      default: nxt = seq;
    endcase
  end
endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
  import useq_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int OP_W       = 4,
  parameter int MAP_LSB    = 2,
  parameter int FETCH_ADDR = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cond_sel,
  input  logic [1:0]        br_kind,
  input  logic [ADDR_W-1:0] target,
  input  logic [OP_W-1:0]   op_bits,
  input  logic              ind_bit,
  input  logic              sign_bit,
  input  logic              zero_flag,
  output logic [ADDR_W-1:0] car
);
  localparam logic [ADDR_W-1:0] RESET_ADDR = ADDR_W'(FETCH_ADDR);

  logic [ADDR_W-1:0] car_q, sbr_q, nxt, map_entry, link_val;
  logic              cond_hit, link_we;

  useq_cond_mux #(.N_SRC(4)) i_cond (
    .src ({zero_flag, sign_bit, ind_bit, 1'b1}),
    .sel (cond_sel),
    .hit (cond_hit)
  );

  useq_map #(.ADDR_W(ADDR_W), .OP_W(OP_W), .MAP_LSB(MAP_LSB)) i_map (
    .op    (op_bits),
    .entry (map_entry)
  );

  useq_next_addr #(.ADDR_W(ADDR_W)) i_next (
    .car       (car_q),
    .link      (sbr_q),
    .target    (target),
    .map_entry (map_entry),
    .kind      (br_kind_t'(br_kind)),
    .taken     (cond_hit),
    .nxt       (nxt),
    .link_we   (link_we),
    .link_val  (link_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      car_q <= RESET_ADDR;
      sbr_q <= '0;
    end else begin
      car_q <= nxt;
      if (link_we) sbr_q <= link_val;
    end
  end

  assign car = car_q;
endmodule

// File: rtl/useq_sequencer_chk.sv
module useq_sequencer_chk #(
  parameter int ADDR_W     = 7,
  parameter int OP_W       = 4,
  parameter int MAP_LSB    = 2,
  parameter int FETCH_ADDR = 64
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        br_kind,
  input logic [ADDR_W-1:0] target,
  input logic [OP_W-1:0]   op_bits,
  input logic [ADDR_W-1:0] car,
  input logic [ADDR_W-1:0] sbr,
  input logic              taken
);
  localparam logic [ADDR_W-1:0] ONE = 1;

  p_reset_fetch_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (car == ADDR_W'(FETCH_ADDR) && sbr == '0));

  p_jump_r3: assert property (@(posedge clk) disable iff (rst)
    (br_kind == 2'b00) |=>
      car == ($past(taken) ? $past(target) : $past(car) + ONE));

  p_call_link_r4: assert property (@(posedge clk) disable iff (rst)
    (br_kind == 2'b01 && taken) |=>
      (car == $past(target) && sbr == $past(car) + ONE));

  p_return_r5: assert property (@(posedge clk) disable iff (rst)
    (br_kind == 2'b10) |=> car == $past(sbr));

  p_map_entry_r6: assert property (@(posedge clk) disable iff (rst)
    (br_kind == 2'b11) |=> car == (ADDR_W'($past(op_bits)) << MAP_LSB));

  p_link_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !(br_kind == 2'b01 && taken) |=> $stable(sbr));
endmodule

bind useq_sequencer useq_sequencer_chk #(
  .ADDR_W(ADDR_W), .OP_W(OP_W), .MAP_LSB(MAP_LSB), .FETCH_ADDR(FETCH_ADDR)
) i_chk (
  .clk     (clk),
  .rst     (rst),
  .br_kind (br_kind),
  .target  (target),
  .op_bits (op_bits),
  .car     (car_q),
  .sbr     (sbr_q),
  .taken   (cond_hit)
);

// File: tb/test_useq_sequencer.sv
module test_useq_sequencer;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] cond_sel = 2'b00;
  logic [1:0] br_kind = 2'b00;
  logic [6:0] target = '0;
  logic [3:0] op_bits = '0;
  logic       ind_bit = 1'b0, sign_bit = 1'b0, zero_flag = 1'b0;
  logic [6:0] car;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  useq_sequencer i_useq_sequencer (
    .clk(clk), .rst(rst), .cond_sel(cond_sel), .br_kind(br_kind),
    .target(target), .op_bits(op_bits), .ind_bit(ind_bit),
    .sign_bit(sign_bit), .zero_flag(zero_flag), .car(car)
  );

  task automatic check(input string tag, input logic [6:0] got, input logic [6:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: car=%0d expected %0d", tag, got, exp);
    end
  endtask

  // drive one microinstruction, let one edge pass, check car at the next falling edge
  task automatic cyc(input logic [1:0] cs, input logic [1:0] br, input logic [6:0] ad,
                     input logic [3:0] op, input logic fi, input logic fs, input logic fz,
                     input logic [6:0] exp, input string tag);
    cond_sel = cs; br_kind = br; target = ad; op_bits = op;
    ind_bit = fi; sign_bit = fs; zero_flag = fz;
    @(posedge clk);
    @(negedge clk);
    check(tag, car, exp);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    cond_sel = 2'b00; br_kind = 2'b00; target = 7'd5;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    check("R1 reset address", car, 7'd64);
    rst = 1'b0;
    cyc(2'b00, 2'b10, 7'd33, 4'd0, 1, 1, 1, 7'd0, "R1 link cleared by reset");
    cyc(2'b00, 2'b00, 7'd64, 4'd0, 0, 0, 0, 7'd64, "R3 jump back to fetch");
  endtask

  task automatic t_cond;
    cyc(2'b00, 2'b00, 7'd51, 4'd0, 0, 0, 0, 7'd51, "R2 always-true select");
    cyc(2'b01, 2'b00, 7'd51, 4'd0, 0, 1, 1, 7'd52, "R2 ind clear falls through");
    cyc(2'b01, 2'b00, 7'd51, 4'd0, 1, 0, 0, 7'd51, "R2 ind set taken");
    cyc(2'b10, 2'b00, 7'd51, 4'd0, 1, 0, 1, 7'd52, "R2 sign clear falls through");
    cyc(2'b10, 2'b00, 7'd51, 4'd0, 0, 1, 0, 7'd51, "R2 sign set taken");
    cyc(2'b11, 2'b00, 7'd51, 4'd0, 1, 1, 0, 7'd52, "R2 zero clear falls through");
    cyc(2'b11, 2'b00, 7'd51, 4'd0, 0, 0, 1, 7'd51, "R3 zero set taken");
  endtask

  task automatic t_call_ret;
    cyc(2'b00, 2'b00, 7'd20,  4'd0, 0, 0, 0, 7'd20, "R3 jump to 20");
    cyc(2'b00, 2'b01, 7'd90,  4'd0, 0, 0, 0, 7'd90, "R4 call taken");
    cyc(2'b01, 2'b00, 7'd3,   4'd0, 0, 0, 0, 7'd91, "R3 step in subroutine");
    cyc(2'b01, 2'b10, 7'd3,   4'd0, 0, 0, 0, 7'd21, "R5 return to link");
    cyc(2'b10, 2'b01, 7'd100, 4'd0, 0, 0, 0, 7'd22, "R4 call untaken steps");
    cyc(2'b00, 2'b10, 7'd100, 4'd0, 0, 0, 0, 7'd21, "R4 untaken call kept link");
  endtask

  task automatic t_hold;
    cyc(2'b00, 2'b01, 7'd70,  4'd0, 0, 0, 0, 7'd70,  "R4 call to 70");
    cyc(2'b00, 2'b11, 7'd9,   4'd5, 0, 0, 0, 7'd20,  "R6 map inside subroutine");
    cyc(2'b00, 2'b00, 7'd120, 4'd0, 0, 0, 0, 7'd120, "R3 jump inside subroutine");
    cyc(2'b11, 2'b10, 7'd9,   4'd0, 0, 0, 0, 7'd22,  "R9 link held, R5 false condition");
  endtask

  task automatic t_nested;
    cyc(2'b00, 2'b01, 7'd80, 4'd0, 0, 0, 0, 7'd80, "R8 first call");
    cyc(2'b00, 2'b01, 7'd96, 4'd0, 0, 0, 0, 7'd96, "R8 second call");
    cyc(2'b00, 2'b10, 7'd0,  4'd0, 0, 0, 0, 7'd81, "R8 return to second link");
    cyc(2'b00, 2'b10, 7'd0,  4'd0, 0, 0, 0, 7'd81, "R8 outer link lost");
  endtask

  task automatic t_map;
    for (int k = 0; k < 16; k++) begin
      cyc(2'b10, 2'b11, 7'd99, 4'(k), 1, 0, 1, 7'(k * 4), $sformatf("R6 map opcode %0d", k));
    end
    cyc(2'b00, 2'b11, 7'd127, 4'd15, 1, 1, 1, 7'd60, "R6 map ignores true condition");
  endtask

  task automatic t_wrap;
    cyc(2'b00, 2'b00, 7'd127, 4'd0, 0, 0, 0, 7'd127, "R7 jump to top");
    cyc(2'b01, 2'b00, 7'd50,  4'd0, 0, 0, 0, 7'd0,   "R7 step wraps");
    cyc(2'b00, 2'b00, 7'd127, 4'd0, 0, 0, 0, 7'd127, "R7 back to top");
    cyc(2'b00, 2'b01, 7'd10,  4'd0, 0, 0, 0, 7'd10,  "R7 call from top");
    cyc(2'b00, 2'b10, 7'd10,  4'd0, 0, 0, 0, 7'd0,   "R7 wrapped link");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run hung, car=%0d expected progress", car);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_cond();
    t_call_ret();
    t_hold();
    t_nested();
    t_map();
    t_wrap();
    t_reset();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule